// File: doc/BRIEF.md
# Multiport Atomic Word Memory

This block is a private on-chip store of 32-bit words that processors reach only through dedicated atomic requests, never through the ordinary load/store path. Each of several request ports presents an opcode, a word handle and an operand. A round-robin arbiter picks one port per cycle. The picked operation reads the word, computes the new value and writes it back in that same cycle, so no other request can come between the read and the write. The old value (or the allocated handle) returns one cycle later together with the number of the port that issued it.

Software must claim a handle before it uses it and must release it afterwards. The block keeps an occupancy bitmap for this purpose. An allocation hands out the lowest free handle and clears that word to zero. When every word is taken, the allocation reports an error. A data operation on a handle that has not been allocated is refused with an error and a zero result. A release of a handle that is already free is also refused, and the bitmap stays as it was.

Top module: `atomic_word_mem`

## Requirements
- R1: After reset every handle is free, no grant or response is active, and port 0 has the highest priority.
- R2: A request on a port is granted in the same cycle that it wins arbitration. At most one port is granted per cycle. In the next cycle `rsp_valid` is high for exactly one cycle and `rsp_port` carries the granted port number.
- R3: Arbitration is round robin. After port k is granted, the search for the next grant starts at port k+1 and wraps around to port 0.
- R4: Opcode 4 (allocate) returns the lowest free handle, zero-extended, in `rsp_data`. It marks that handle as used and sets its word to zero.
- R5: An allocate while every handle is in use returns `rsp_err`=1 and `rsp_data`=0, and leaves the bitmap unchanged.
- R6: Opcode 5 (release) frees a used handle and responds with `rsp_err`=0. Releasing a free handle responds with `rsp_err`=1 and changes nothing.
- R7: Opcode 0 (load) returns the word and leaves it unchanged.
- R8: Opcode 1 (test-and-set) returns the old word and writes all ones.
- R9: Opcode 2 (exchange) returns the old word and writes the operand.
- R10: Opcode 3 (increment) returns the old word and writes the old word plus one, modulo 2^32.
- R11: Opcodes 0 to 3 on a free handle return `rsp_err`=1 and `rsp_data`=0 and write nothing. Every error response carries `rsp_data`=0.
- R12: Opcodes 6 and 7 are undefined. They return `rsp_err`=1 and `rsp_data`=0 and change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NP | Per-port request; held until granted |
| req_op | input | 3*NP | Per-port opcode (port p at bits 3p+2:3p) |
| req_idx | input | IW*NP | Per-port word handle |
| req_wdata | input | 32*NP | Per-port operand for exchange |
| req_grant | output | NP | One-hot grant, combinational in the request cycle |
| rsp_valid | output | 1 | Response strobe, one cycle after the grant |
| rsp_port | output | PW | Port that the response belongs to |
| rsp_data | output | 32 | Old word, allocated handle, or zero |
| rsp_err | output | 1 | Operation refused |

## Verification
The grant is combinational. It is due in the same cycle as the request, so the bench compares `req_grant` shortly after driving the inputs on the falling edge. The response passes through one register. It is due in the following cycle and is compared on the next falling edge, against the bench's own word and bitmap model. The model has already been updated in the arbitration order that the bench predicts. Any state change made by a granted operation is visible to the operation granted in the very next cycle. Back-to-back requests from all ports on the same handle therefore show the expected old values in sequence.

// File: rtl/atomic_word_mem_pkg.sv
package atomic_word_mem_pkg;

    localparam int WORD_W = 32;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 3'd0,
        OP_TAS   = 3'd1,
        OP_SWAP  = 3'd2,
        OP_INC   = 3'd3,
        OP_ALLOC = 3'd4,
        OP_FREE  = 3'd5
    } aop_e;

    typedef struct packed {
        logic              wr_en;
        logic [WORD_W-1:0] wr_data;
        logic [WORD_W-1:0] rsp_data;
        logic              rsp_err;
        logic              set_used;
        logic              clr_used;
        logic              at_alloc;
    } exec_t;

    // Opcodes that read and maybe rewrite an existing word
    function automatic logic is_word_op(logic [OP_W-1:0] op);
        return op <= 3'd3;
    endfunction

endpackage

// File: rtl/aw_rr_arbiter.sv
module aw_rr_arbiter #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [PW-1:0] gidx,
    output logic          any
);
    logic [PW-1:0] last_q;

    always_comb begin
        grant = '0;
        gidx  = '0;
        any   = 1'b0;
        for (int off = 1; off <= N; off++) begin
            int cand;
            cand = (int'(last_q) + off) % N;
            if (!any && req[cand]) begin
                any         = 1'b1;
                grant[cand] = 1'b1;
                gidx        = PW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= PW'(N - 1);
        end else if (any) begin
            last_q <= gidx;
        end
    end
endmodule

// File: rtl/aw_free_map.sv
module aw_free_map #(
    parameter int WORDS = 1024,
    parameter int IW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    input  logic [IW-1:0] chk_idx,
    output logic          chk_used,
    output logic          any_free,
    output logic [IW-1:0] first_free
);
    logic [WORDS-1:0] used_q;

    assign chk_used = used_q[chk_idx];
    assign any_free = ~&used_q;

    // Scan downward so the lowest free position wins
    always_comb begin
        first_free = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (!used_q[i]) begin
                first_free = IW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used_q <= '0;
        end else begin
            if (set_en) begin
                used_q[set_idx] <= 1'b1;
            end
            if (clr_en) begin
                used_q[clr_idx] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/aw_word_exec.sv
module aw_word_exec
    import atomic_word_mem_pkg::*;
#(
    parameter int IW = 10
) (
    input  logic [OP_W-1:0]   op,
    input  logic              idx_used,
    input  logic              any_free,
    input  logic [IW-1:0]     first_free,
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] operand,
    output exec_t             res
);
    always_comb begin
        res = '0;
        if (is_word_op(op)) begin
            if (!idx_used) begin
                res.rsp_err = 1'b1;
            end else begin
                res.rsp_data = old_word;
                unique case (op)
                    OP_TAS: begin
                        res.wr_en   = 1'b1;
                        res.wr_data = '1;
                    end
                    OP_SWAP: begin
                        res.wr_en   = 1'b1;
                        res.wr_data = operand;
                    end
                    OP_INC: begin
                        res.wr_en   = 1'b1;
                        res.wr_data = old_word + WORD_W'(1);
                    end
                    default: res.wr_en = 1'b0;
                endcase
            end
        end else if (op == OP_ALLOC) begin
            if (any_free) begin
                res.set_used = 1'b1;
                res.at_alloc = 1'b1;
                res.wr_en    = 1'b1;
                res.wr_data  = '0;
                res.rsp_data = WORD_W'(first_free);
            end else begin
                res.rsp_err = 1'b1;
            end
        end else if (op == OP_FREE) begin
            if (idx_used) begin
                res.clr_used = 1'b1;
            end else begin
                res.rsp_err = 1'b1;
            end
        end else begin
            res.rsp_err = 1'b1;
        end
    end
endmodule

// File: rtl/atomic_word_mem.sv
module atomic_word_mem
    import atomic_word_mem_pkg::*;
#(
    parameter int NP    = 4,
    parameter int WORDS = 1024,
    localparam int IW   = $clog2(WORDS),
    localparam int PW   = (NP > 1) ? $clog2(NP) : 1,
    localparam int DW   = WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NP-1:0]    req_valid,
    input  logic [NP*3-1:0]  req_op,
    input  logic [NP*IW-1:0] req_idx,
    input  logic [NP*DW-1:0] req_wdata,
    output logic [NP-1:0]    req_grant,
    output logic             rsp_valid,
    output logic [PW-1:0]    rsp_port,
    output logic [DW-1:0]    rsp_data,
    output logic             rsp_err
);
    logic [NP-1:0]   req_live;
    logic [NP-1:0]   grant;
    logic [PW-1:0]   gidx;
    logic            any_grant;
    logic [OP_W-1:0] sel_op;
    logic [IW-1:0]   sel_idx;
    logic [DW-1:0]   sel_wd;
    logic            idx_used;
    logic            any_free;
    logic [IW-1:0]   first_free;
    logic [IW-1:0]   wr_addr;
    logic [DW-1:0]   old_word;
    exec_t           res;

    logic [DW-1:0]   mem_q [WORDS];

    assign req_live = rst ? '0 : req_valid;

    aw_rr_arbiter #(.N(NP), .PW(PW)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (req_live),
        .grant (grant),
        .gidx  (gidx),
        .any   (any_grant)
    );

    assign sel_op  = req_op[int'(gidx)*OP_W +: OP_W];
    assign sel_idx = req_idx[int'(gidx)*IW +: IW];
    assign sel_wd  = req_wdata[int'(gidx)*DW +: DW];

    aw_free_map #(.WORDS(WORDS), .IW(IW)) u_map (
        .clk        (clk),
        .rst        (rst),
        .set_en     (any_grant & res.set_used),
        .set_idx    (first_free),
        .clr_en     (any_grant & res.clr_used),
        .clr_idx    (sel_idx),
        .chk_idx    (sel_idx),
        .chk_used   (idx_used),
        .any_free   (any_free),
        .first_free (first_free)
    );

    assign old_word = mem_q[sel_idx];

    aw_word_exec #(.IW(IW)) u_exec (
        .op         (sel_op),
        .idx_used   (idx_used),
        .any_free   (any_free),
        .first_free (first_free),
        .old_word   (old_word),
        .operand    (sel_wd),
        .res        (res)
    );

    assign wr_addr = res.at_alloc ? first_free : sel_idx;

    always_ff @(posedge clk) begin
        if (any_grant && res.wr_en) begin
            mem_q[wr_addr] <= res.wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_port  <= '0;
            rsp_data  <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= any_grant;
            rsp_port  <= gidx;
            rsp_data  <= any_grant ? res.rsp_data : '0;
            rsp_err   <= any_grant & res.rsp_err;
        end
    end

    assign req_grant = grant;
endmodule

// File: rtl/atomic_word_mem_chk.sv
module atomic_word_mem_chk #(
    parameter int NP = 4,
    parameter int PW = 2,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [NP-1:0] req_valid,
    input logic [NP-1:0] req_grant,
    input logic          rsp_valid,
    input logic [PW-1:0] rsp_port,
    input logic [DW-1:0] rsp_data,
    input logic          rsp_err
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_grant)); // R2

    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        (req_grant & ~req_valid) == '0); // R2

    AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        (|req_grant) |=> rsp_valid); // R2

    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(|req_grant) |=> !rsp_valid); // R2

    AST_RSP_PORT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_grant) == (NP'(1) << rsp_port)); // R2

    AST_ROTATE: assert property (@(posedge clk) disable iff (rst)
        ((|$past(req_grant)) && (|(req_valid & ~$past(req_grant))))
        |-> (req_grant & $past(req_grant)) == '0); // R3

    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> rsp_data == '0); // R11
endmodule

bind atomic_word_mem atomic_word_mem_chk #(.NP(NP), .PW(PW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_grant (req_grant),
    .rsp_valid (rsp_valid),
    .rsp_port  (rsp_port),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err)
);

// File: tb/atomic_word_mem_test.sv
`timescale 1ns/1ps
module atomic_word_mem_test;
    localparam int NP    = 4;
    localparam int WORDS = 1024;
    localparam int IW    = 10;
    localparam int PW    = 2;
    localparam int DW    = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NP-1:0]    req_valid = '0;
    logic [NP*3-1:0]  req_op = '0;
    logic [NP*IW-1:0] req_idx = '0;
    logic [NP*DW-1:0] req_wdata = '0;
    logic [NP-1:0]    req_grant;
    logic             rsp_valid;
    logic [PW-1:0]    rsp_port;
    logic [DW-1:0]    rsp_data;
    logic             rsp_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    atomic_word_mem #(.NP(NP), .WORDS(WORDS)) uut (.*);

    // Reference model
    logic [DW-1:0] m_mem  [WORDS];
    bit            m_used [WORDS];
    int            m_last = NP - 1;

    bit            pend [NP];
    logic [2:0]    p_op [NP];
    logic [IW-1:0] p_idx[NP];
    logic [DW-1:0] p_wd [NP];

    bit            e_v = 0;
    int            e_port;
    logic [DW-1:0] e_data;
    bit            e_err;
    string         e_tag;

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < WORDS; i++) if (!m_used[i]) return i;
        return -1;
    endfunction

    task automatic model_exec(int p);
        logic [2:0] o = p_op[p];
        int i = int'(p_idx[p]);
        e_v = 1; e_port = p; e_data = '0; e_err = 0;
        if (o <= 3) begin
            if (!m_used[i]) begin
                e_err = 1; e_tag = "R11";
            end else begin
                e_data = m_mem[i];
                case (o)
                    3'd0: e_tag = "R7";
                    3'd1: begin m_mem[i] = '1; e_tag = "R8"; end
                    3'd2: begin m_mem[i] = p_wd[p]; e_tag = "R9"; end
                    default: begin m_mem[i] = m_mem[i] + 1; e_tag = "R10"; end
                endcase
            end
        end else if (o == 3'd4) begin
            int f = lowest_free();
            if (f < 0) begin
                e_err = 1; e_tag = "R5";
            end else begin
                m_used[f] = 1; m_mem[f] = '0; e_data = DW'(f); e_tag = "R4";
            end
        end else if (o == 3'd5) begin
            e_tag = "R6";
            if (m_used[i]) m_used[i] = 0; else e_err = 1;
        end else begin
            e_err = 1; e_tag = "R12";
        end
    endtask

    task automatic step();
        int w;
        logic [NP-1:0] expg;
        @(negedge clk);
        if (e_v)
            check({rsp_valid, rsp_err, rsp_port, rsp_data} == {1'b1, e_err, PW'(e_port), e_data},
                  e_tag, 64'({rsp_valid, rsp_err, rsp_port, rsp_data}),
                  64'({1'b1, e_err, PW'(e_port), e_data}));
        else
            check(rsp_valid == 1'b0, "R2", 64'(rsp_valid), 64'(0));
        for (int p = 0; p < NP; p++) begin
            req_valid[p]          = pend[p];
            req_op[p*3 +: 3]      = p_op[p];
            req_idx[p*IW +: IW]   = p_idx[p];
            req_wdata[p*DW +: DW] = p_wd[p];
        end
        #1;
        w = -1;
        for (int off = 1; off <= NP; off++) begin
            int c = (m_last + off) % NP;
            if (w < 0 && pend[c]) w = c;
        end
        expg = (w >= 0) ? (NP'(1) << w) : '0;
        check(req_grant == expg, "R3", 64'(req_grant), 64'(expg));
        e_v = 0;
        if (w >= 0) begin
            model_exec(w);
            pend[w] = 0;
            m_last  = w;
        end
    endtask

    task automatic issue(int p, logic [2:0] op, int idx, logic [DW-1:0] wd);
        while (pend[p]) step();
        pend[p] = 1; p_op[p] = op; p_idx[p] = IW'(idx); p_wd[p] = wd;
    endtask

    task automatic drain();
        bit busy = 1;
        while (busy) begin
            busy = 0;
            for (int p = 0; p < NP; p++) if (pend[p]) busy = 1;
            if (busy) step();
        end
        step();
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin m_used[i] = 0; m_mem[i] = '0; end
        for (int p = 0; p < NP; p++) begin pend[p] = 0; p_op[p] = '0; p_idx[p] = '0; p_wd[p] = '0; end
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b0 && req_grant == '0, "R1", 64'({rsp_valid, req_grant}), 64'(0));
        rst = 1'b0;

        // R1: all ports at once, port 0 first, handles from 0 upward
        for (int p = 0; p < NP; p++) issue(p, 3'd4, 0, '0);
        drain();
        // R11: data op on free handle; R12: undefined opcodes
        issue(1, 3'd3, 200, '0);
        issue(2, 3'd6, 1, '0);
        issue(3, 3'd7, 2, '0);
        drain();
        issue(0, 3'd0, 1, '0);          // R12 left handle 1 unchanged
        drain();
        // R8, R9, R10 on handle 2
        issue(0, 3'd1, 2, '0);
        drain();
        issue(0, 3'd0, 2, '0);
        issue(0, 3'd3, 2, '0);          // R10 wrap from all ones
        issue(0, 3'd0, 2, '0);
        issue(0, 3'd2, 2, 32'hA5A5_1234);
        issue(0, 3'd0, 2, '0);
        drain();
        // R10: all ports increment same handle back to back
        for (int p = 0; p < NP; p++) issue(p, 3'd3, 3, '0);
        drain();
        issue(2, 3'd0, 3, '0);
        drain();

        // Constrained random mix over a small handle window
        for (int k = 0; k < 8; k++) issue(k % NP, 3'd4, 0, '0);
        drain();
        for (int cyc = 0; cyc < 2000; cyc++) begin
            for (int p = 0; p < NP; p++) begin
                if (!pend[p] && ($urandom % 2 == 0)) begin
                    pend[p]  = 1;
                    p_op[p]  = 3'($urandom % 8);
                    p_idx[p] = ($urandom % 4 == 0) ? IW'($urandom) : IW'($urandom % 16);
                    p_wd[p]  = $urandom;
                end
            end
            step();
        end
        drain();

        // R5: exhaust the store, then one more allocation
        while (lowest_free() >= 0) begin
            issue(int'($urandom % NP), 3'd4, 0, '0);
            drain();
        end
        issue(0, 3'd4, 0, '0);
        drain();
        // R6: release, double release, reallocate the same handle
        issue(1, 3'd5, 7, '0);
        issue(1, 3'd5, 7, '0);
        issue(1, 3'd4, 0, '0);
        issue(1, 3'd0, 7, '0);
        issue(1, 3'd4, 0, '0);          // R5 again: full after refill
        drain();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule